// File: doc/BRIEF.md
# Host Strobe-Bus Access Master

This block lets a host-side subsystem perform single-word reads and writes into the internal memory and registers of a slave processor over an asynchronous strobe bus. Commands arrive on a valid/ready stream: a command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` falls for the whole access, so the command source must hold its fields steady until it sees the acceptance. Each accepted command returns exactly one response as a single-cycle `rsp_valid` pulse that carries the read word and an error flag. The response has no back-pressure: the consumer must take it in the cycle it appears.

On the bus side the block owns the bus through an active-low request/grant handshake. It drives chip select, separate read and write strobes, the address and the write data with its own enable, and it samples an open-drain style ready line that the slave pulls low to stretch a strobe. Every minimum time from the bus timing is turned into whole clock cycles from a clock-period parameter, with rounding up. Grant and ready pass through a synchroniser before use. A timeout stops an access whose ready never comes back. Once granted, the bus stays owned for as long as commands keep arriving, and it is handed back as soon as none is pending.

Top module: `hsm_host_bus_master`

## Requirements
- R1: While reset is held and after it, with no command, bus request, chip select, read strobe and write strobe are all high, the data enable is low, `cmd_ready` is high and `rsp_valid` is low.
- R2: A command is taken only on an edge with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is low in the cycle after acceptance and stays low until that access has finished.
- R3: Chip select and bus request (active low) fall together when a command is taken from the released state. Neither strobe falls until grant (active low) has been seen low through the synchroniser, and a strobe is never low while request or chip select is high.
- R4: From the cycle request falls until grant has been taken, the address bus carries the command address with bit MARK_BIT (default 31) forced to 1, so the first access never points into the memory-mapped register space.
- R5: Address and chip select are valid at least one full cycle before a strobe falls, and they stay unchanged until one cycle after it rises.
- R6: A strobe is low for at least max(ceil(WR_LOW_PS/CLK_PS), SYNC_STAGES+ceil(RDY_LAG_PS/CLK_PS)) cycles (4 by default). After that it stays low until ready is sampled high. With default parameters it rises on the second rising edge after the first edge that samples ready high, so a slave that releases ready W cycles after the strobe is seen low gives a strobe W+4 cycles long.
- R7: For a read, the word on `bus_data_i` is captured in the cycle the released ready is acted on, while the read strobe is still low. It is returned on `rsp_rdata` with `rsp_valid`.
- R8: `bus_data_oe` is high only during write accesses, from the setup cycle through the hold cycle, with the write word on `bus_data_o`. It is never high while the read strobe is low, nor within ceil(DATA_RELEASE_PS/CLK_PS) cycles (2) after the read strobe rises.
- R9: Between two strobes of back-to-back accesses, both strobes stay high for at least the hold cycle, max(ceil(STROBE_GAP_PS/CLK_PS), IDLE_CYCLES) idle cycles (2 by default), one re-arm cycle and one setup cycle, which is 5 cycles by default.
- R10: If the strobe has been low for TIMEOUT_CYCLES cycles (64) without ready being released, the strobe is raised and the response is returned with `rsp_err`=1. A completed access returns `rsp_err`=0.
- R11: When an access ends with a command already waiting, the next access starts with no release of bus request in between. When no command is waiting in the cycle after the idle gap, request and chip select both go high.
- R12: `rsp_valid` is a single-cycle pulse, one for each accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Word address |
| cmd_wdata | input | DW | Write word |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read word, valid with rsp_valid |
| rsp_err | output | 1 | Access aborted by timeout, valid with rsp_valid |
| bus_req_n | output | 1 | Bus request, active low |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | AW | Bus address |
| bus_data_o | output | DW | Write data toward the pad |
| bus_data_oe | output | 1 | Data pad output enable |
| bus_data_i | input | DW | Read data from the pad |
| bus_grant_n | input | 1 | Bus grant, active low, asynchronous |
| bus_ready | input | 1 | Slave ready, low = stretch strobe, asynchronous |

## Verification
Writes and reads go to a slave model whose ready release comes 0, 2 or 10 cycles after it sees the strobe. The zero case exposes the fixed strobe minimum, and the long case shows whether the strobe truly waits on ready and how many cycles the synchroniser adds. A slave that never releases ready tells a correct timeout abort apart from a hang or a silent success. Isolated commands are contrasted with a command offered during the idle gap: the first kind must release request, and the second must keep it low while still respecting the strobe gap and the data turnaround after a read.

// File: rtl/hsm_pkg.sv
package hsm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_REQ    = 3'd1,
    ST_SETUP  = 3'd2,
    ST_STROBE = 3'd3,
    ST_HOLD   = 3'd4,
    ST_GAP    = 3'd5,
    ST_OWN    = 3'd6
  } hsm_state_e;

  // picoseconds to whole cycles, rounding up
  function automatic int ps_to_cyc(input int ps, input int period_ps);
    return (ps + period_ps - 1) / period_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hsm_sync.sv
module hsm_sync #(
  parameter int              W      = 1,
  parameter int              STAGES = 2,
  parameter logic [W-1:0]    INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= INIT;
        else        pipe[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= INIT;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/hsm_timer.sv
module hsm_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         en,
  input  logic [W-1:0] ld_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (load)               cnt_q <= ld_val;
    else if (en && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/hsm_dpath.sv
module hsm_dpath #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          capture,
  input  logic [DW-1:0] bus_rdata,
  input  logic          abort,
  input  logic          finish,
  output logic          op_write,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err
);

  // command registers: held stable for the whole access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_write <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
    end else if (accept) begin
      op_write <= cmd_write;
      op_addr  <= cmd_addr;
      op_wdata <= cmd_wdata;
    end
  end

  // read word and abort flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      if (accept)       rsp_err <= 1'b0;
      else if (abort)   rsp_err <= 1'b1;
      if (accept)       rsp_rdata <= '0;
      else if (capture) rsp_rdata <= bus_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= finish;
  end

endmodule

// File: rtl/hsm_host_bus_master.sv
module hsm_host_bus_master
  import hsm_pkg::*;
#(
  parameter int AW              = 32,
  parameter int DW              = 32,
  parameter int CLK_PS          = 5000,
  parameter int ADDR_SETUP_PS   = 5000,
  parameter int WR_LOW_PS       = 7000,
  parameter int HOLD_PS         = 2000,
  parameter int STROBE_GAP_PS   = 6000,
  parameter int DATA_RELEASE_PS = 8000,
  parameter int RDY_LAG_PS      = 10000,
  parameter int IDLE_CYCLES     = 2,
  parameter int SYNC_STAGES     = 2,
  parameter int TIMEOUT_CYCLES  = 64,
  parameter int MARK_BIT        = AW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          bus_req_n,
  output logic          bus_cs_n,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_data_oe,
  input  logic [DW-1:0] bus_data_i,
  input  logic          bus_grant_n,
  input  logic          bus_ready
);

  // cycle budgets derived from the bus timing
  localparam int SETUP_CYC = imax(1, ps_to_cyc(ADDR_SETUP_PS, CLK_PS));
  localparam int HOLD_CYC  = imax(1, ps_to_cyc(HOLD_PS, CLK_PS));
  localparam int STRB_MIN  = imax(ps_to_cyc(WR_LOW_PS, CLK_PS),
                                  SYNC_STAGES + ps_to_cyc(RDY_LAG_PS, CLK_PS));
  localparam int GAP_WR    = imax(1, imax(ps_to_cyc(STROBE_GAP_PS, CLK_PS), IDLE_CYCLES));
  localparam int GAP_RD    = imax(GAP_WR, ps_to_cyc(DATA_RELEASE_PS, CLK_PS));
  localparam int PH_MAX    = imax(imax(SETUP_CYC, HOLD_CYC), imax(STRB_MIN, GAP_RD));
  localparam int PH_W      = $clog2(PH_MAX + 1);
  localparam int TO_W      = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [AW-1:0] MARK_MASK = AW'(1) << MARK_BIT;

  hsm_state_e state_q, state_d;

  logic          gnt_s_n, rdy_s;
  logic          ph_load, ph_zero, to_load, to_zero;
  logic [PH_W-1:0] ph_val;
  logic          accept, capture, abort, finish, done_ok;
  logic          op_write;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata;

  // ---------------------------------------------------------------
  // asynchronous inputs through a synchroniser chain
  // ---------------------------------------------------------------
  hsm_sync #(
    .W      (2),
    .STAGES (SYNC_STAGES),
    .INIT   (2'b11)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bus_grant_n, bus_ready}),
    .q     ({gnt_s_n, rdy_s})
  );

  // phase timer: setup, strobe minimum, hold and idle gap
  hsm_timer #(.W(PH_W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ph_load),
    .en     (1'b1),
    .ld_val (ph_val),
    .zero   (ph_zero)
  );

  // watchdog on a stretched strobe
  hsm_timer #(.W(TO_W)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (to_load),
    .en     (state_q == ST_STROBE),
    .ld_val (TO_W'(TIMEOUT_CYCLES - 1)),
    .zero   (to_zero)
  );

  assign cmd_ready = (state_q == ST_IDLE) || (state_q == ST_OWN);
  assign accept    = cmd_valid && cmd_ready;

  assign done_ok = (state_q == ST_STROBE) && ph_zero && rdy_s;
  assign abort   = (state_q == ST_STROBE) && !done_ok && to_zero;
  assign capture = done_ok && !op_write;
  assign finish  = (state_q == ST_HOLD) && ph_zero;

  // ---------------------------------------------------------------
  // access sequencer
  // ---------------------------------------------------------------
  always_comb begin
    state_d = state_q;
    ph_load = 1'b0;
    ph_val  = '0;
    to_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) state_d = ST_REQ;
      end
      ST_REQ: begin
        if (!gnt_s_n) begin
          state_d = ST_SETUP;
          ph_load = 1'b1;
          ph_val  = PH_W'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (ph_zero) begin
          state_d = ST_STROBE;
          ph_load = 1'b1;
          ph_val  = PH_W'(STRB_MIN - 1);
          to_load = 1'b1;
        end
      end
      ST_STROBE: begin
        if (done_ok || abort) begin
          state_d = ST_HOLD;
          ph_load = 1'b1;
          ph_val  = PH_W'(HOLD_CYC - 1);
        end
      end
      ST_HOLD: begin
        if (ph_zero) begin
          state_d = ST_GAP;
          ph_load = 1'b1;
          ph_val  = op_write ? PH_W'(GAP_WR - 1) : PH_W'(GAP_RD - 1);
        end
      end
      ST_GAP: begin
        if (ph_zero) state_d = ST_OWN;
      end
      ST_OWN: begin
        if (accept) begin
          state_d = ST_SETUP;
          ph_load = 1'b1;
          ph_val  = PH_W'(SETUP_CYC - 1);
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  hsm_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .capture   (capture),
    .bus_rdata (bus_data_i),
    .abort     (abort),
    .finish    (finish),
    .op_write  (op_write),
    .op_addr   (op_addr),
    .op_wdata  (op_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

  // ---------------------------------------------------------------
  // bus pins decoded from registered state
  // ---------------------------------------------------------------
  logic in_access;
  assign in_access = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);

  assign bus_req_n   = (state_q == ST_IDLE);
  assign bus_cs_n    = (state_q == ST_IDLE);
  assign bus_rd_n    = !((state_q == ST_STROBE) && !op_write);
  assign bus_wr_n    = !((state_q == ST_STROBE) &&  op_write);
  assign bus_addr    = (state_q == ST_REQ) ? (op_addr | MARK_MASK) : op_addr;
  assign bus_data_o  = op_wdata;
  assign bus_data_oe = in_access && op_write;

endmodule

// File: rtl/hsm_checker.sv
module hsm_checker
  import hsm_pkg::*;
#(
  parameter int AW       = 32,
  parameter int MARK_BIT = AW - 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          rsp_valid,
  input logic          bus_req_n,
  input logic          bus_cs_n,
  input logic          bus_rd_n,
  input logic          bus_wr_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_data_oe,
  input hsm_state_e    state_q
);

  logic strobe_lo;
  assign strobe_lo = !bus_rd_n || !bus_wr_n;

  a_r1_req_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_n |-> bus_cs_n);

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  a_r2_busy_while_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_lo |-> !cmd_ready);

  a_r3_strobe_owned: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_lo |-> (!bus_req_n && !bus_cs_n));

  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  a_r4_marker_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req_n) |-> bus_addr[MARK_BIT]);

  a_r5_addr_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> ($past(!bus_cs_n) && $stable(bus_addr)));

  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_lo |=> ($stable(bus_addr) && !bus_cs_n));

  a_r6_wr_low_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |=> !bus_wr_n);

  a_r8_oe_not_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> bus_rd_n);

  a_r8_read_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_n) |=> !bus_data_oe);

  a_r9_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_rd_n) || $rose(bus_wr_n)) |=> (bus_rd_n && bus_wr_n));

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r11_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    state_q inside {ST_IDLE, ST_REQ, ST_SETUP, ST_STROBE, ST_HOLD, ST_GAP, ST_OWN});

endmodule

bind hsm_host_bus_master hsm_checker #(.AW(AW), .MARK_BIT(MARK_BIT)) u_chk (.*);

// File: tb/hsm_host_bus_master_tb.sv
module hsm_host_bus_master_tb_top;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int TIMEOUT = 64;
  localparam int MIN_GAP = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_err;
  logic          bus_req_n, bus_cs_n, bus_rd_n, bus_wr_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data_o;
  logic          bus_data_oe;
  logic [DW-1:0] bus_data_i = '0;
  logic          bus_grant_n = 1'b1;
  logic          bus_ready = 1'b1;

  always #2.5 clk = ~clk;

  hsm_host_bus_master dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bus_req_n(bus_req_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe),
    .bus_data_i(bus_data_i), .bus_grant_n(bus_grant_n), .bus_ready(bus_ready)
  );

  int checks = 0;
  int errors = 0;

  // slave model controls and monitor counters
  logic [DW-1:0] mem [16];
  int  slv_wait = 2;
  bit  slv_stuck = 1'b0;
  int  gnt_delay = 3;
  int  low_len = 0;
  int  last_low = 0;
  int  gap_len = 0;
  bit  had_prev = 1'b0;
  int  since_rd = 99;
  int  req_rises = 0;
  int  v_gnt = 0, v_mark = 0, v_addr = 0, v_oe = 0, v_turn = 0, v_gap = 0, v_rdy = 0;
  int  mark_seen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // slave: reacts and observes at each falling edge
  initial begin : slave
    int  gcnt = 0;
    int  wcnt = 0;
    bit  strobe_prev = 1'b0;
    bit  wr_prev = 1'b0;
    bit  rd_prev = 1'b0;
    bit  req_prev = 1'b1;
    logic [AW-1:0] fall_addr = '0;
    logic [AW-1:0] addr_prev = '0;
    bit  cs_prev = 1'b1;
    forever begin
      @(negedge clk);
      begin
        bit strobe_now;
        strobe_now = !bus_rd_n || !bus_wr_n;
        if (!req_prev && bus_req_n) req_rises++;
        // grant follows request after a delay
        if (bus_req_n) begin gcnt = 0; bus_grant_n = 1'b1; end
        else if (gcnt >= gnt_delay) bus_grant_n = 1'b0;
        else gcnt++;
        if (!bus_req_n && bus_grant_n && !bus_cs_n) begin
          mark_seen++;
          if (!bus_addr[31]) v_mark++;
        end
        if (bus_req_n) had_prev = 1'b0;
        since_rd = (since_rd < 99) ? since_rd + 1 : 99;
        if (strobe_now) begin
          if (!strobe_prev) begin
            low_len = 0;
            wcnt = 0;
            fall_addr = bus_addr;
            if (cs_prev || addr_prev != bus_addr) v_addr++;
            if (had_prev && gap_len < MIN_GAP) v_gap++;
            bus_ready = 1'b0;
          end else begin
            if (!slv_stuck && wcnt >= slv_wait) bus_ready = 1'b1;
            else wcnt++;
          end
          low_len++;
          if (bus_grant_n || bus_req_n || bus_cs_n) v_gnt++;
          if (bus_addr != fall_addr) v_addr++;
          if (!bus_rd_n) bus_data_i = mem[bus_addr[5:2]];
          if (!bus_rd_n && bus_data_oe) v_oe++;
        end else begin
          if (strobe_prev) begin
            last_low = low_len;
            if (!bus_ready && !slv_stuck) v_rdy++;
            if (bus_addr != fall_addr || bus_cs_n) v_addr++;
            if (wr_prev) begin
              if (!bus_data_oe) v_oe++;
              mem[bus_addr[5:2]] = bus_data_o;
            end
            if (rd_prev) since_rd = 0;
            gap_len = 0;
            had_prev = 1'b1;
          end
          gap_len++;
          bus_ready = 1'b1;
          bus_data_i = '0;
        end
        if (bus_data_oe && since_rd < 2) v_turn++;
        strobe_prev = strobe_now;
        wr_prev = !bus_wr_n;
        rd_prev = !bus_rd_n;
        req_prev = bus_req_n;
        addr_prev = bus_addr;
        cs_prev = bus_cs_n;
      end
    end
  end

  // call at a falling edge; returns at the falling edge after the response
  task automatic do_cmd(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output bit err);
    bit got = 1'b0;
    cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R2", "cmd_ready after accept", cmd_ready, 0);
    rd = '0; err = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (rsp_valid) begin got = 1'b1; rd = rsp_rdata; err = rsp_err; break; end
      @(negedge clk);
    end
    chk(got, "R12", "response pulse seen", got, 1);
    @(negedge clk);
    chk(!rsp_valid, "R12", "pulse one cycle wide", rsp_valid, 0);
  endtask

  task automatic t_reset();
    chk(bus_req_n && bus_cs_n, "R1", "request/select idle", {bus_req_n, bus_cs_n}, 2'b11);
    chk(bus_rd_n && bus_wr_n, "R1", "strobes idle", {bus_rd_n, bus_wr_n}, 2'b11);
    chk(!bus_data_oe, "R1", "data enable off", bus_data_oe, 0);
    chk(cmd_ready && !rsp_valid, "R1", "ready/valid", {cmd_ready, rsp_valid}, 2'b10);
  endtask

  task automatic t_write_read();
    logic [DW-1:0] rd; bit err;
    slv_wait = 2;
    do_cmd(1'b1, 32'h0000_0010, 32'hA5A5_1234, rd, err);
    chk(err == 0, "R10", "write completes without error", err, 0);
    chk(mem[4] == 32'hA5A5_1234, "R8", "slave got write word", mem[4], 32'hA5A5_1234);
    repeat (8) @(negedge clk);
    do_cmd(1'b0, 32'h0000_0010, '0, rd, err);
    chk(rd == 32'hA5A5_1234, "R7", "read back written word", rd, 32'hA5A5_1234);
    repeat (8) @(negedge clk);
    mem[9] = 32'h0BAD_F00D;
    do_cmd(1'b0, 32'h0000_0024, '0, rd, err);
    chk(rd == 32'h0BAD_F00D, "R7", "read preset word", rd, 32'h0BAD_F00D);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_wait_states();
    logic [DW-1:0] rd; bit err;
    slv_wait = 10;
    mem[3] = 32'h1357_9BDF;
    do_cmd(1'b0, 32'h0000_000C, '0, rd, err);
    chk(last_low == 14, "R6", "long stretch strobe length", last_low, 14);
    chk(rd == 32'h1357_9BDF, "R7", "read after long stretch", rd, 32'h1357_9BDF);
    repeat (8) @(negedge clk);
    slv_wait = 0;
    do_cmd(1'b1, 32'h0000_0008, 32'h2468_ACE0, rd, err);
    chk(last_low == 4, "R6", "minimum strobe length", last_low, 4);
    repeat (8) @(negedge clk);
    slv_wait = 2;
  endtask

  task automatic t_timeout();
    logic [DW-1:0] rd; bit err;
    slv_stuck = 1'b1;
    do_cmd(1'b0, 32'h0000_0004, '0, rd, err);
    chk(err == 1, "R10", "timeout flagged", err, 1);
    chk(last_low == TIMEOUT, "R10", "strobe cut at timeout", last_low, TIMEOUT);
    slv_stuck = 1'b0;
    repeat (8) @(negedge clk);
    do_cmd(1'b0, 32'h0000_0004, '0, rd, err);
    chk(err == 0, "R10", "error cleared on next access", err, 0);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_back_to_back();
    logic [DW-1:0] rd; bit err;
    req_rises = 0;
    do_cmd(1'b1, 32'h0000_0030, 32'hCAFE_0001, rd, err);
    do_cmd(1'b0, 32'h0000_0030, '0, rd, err);
    chk(req_rises == 0, "R11", "request held across back-to-back", req_rises, 0);
    chk(rd == 32'hCAFE_0001, "R7", "back-to-back read data", rd, 32'hCAFE_0001);
    do_cmd(1'b1, 32'h0000_0034, 32'hCAFE_0002, rd, err);
    chk(req_rises == 0, "R11", "request held after read", req_rises, 0);
    chk(mem[13] == 32'hCAFE_0002, "R8", "write after read", mem[13], 32'hCAFE_0002);
    repeat (10) @(negedge clk);
    chk(bus_req_n && bus_cs_n, "R11", "bus released when queue empty", {bus_req_n, bus_cs_n}, 2'b11);
    chk(req_rises == 1, "R11", "exactly one release", req_rises, 1);
  endtask

  task automatic t_monitors();
    chk(v_gnt == 0, "R3", "strobe without grant/select", v_gnt, 0);
    chk(mark_seen > 0 && v_mark == 0, "R4", "marker address violations", v_mark, 0);
    chk(v_addr == 0, "R5", "address/select setup-hold violations", v_addr, 0);
    chk(v_rdy == 0, "R6", "strobe raised with ready low", v_rdy, 0);
    chk(v_oe == 0, "R8", "enable during read or missing in write", v_oe, 0);
    chk(v_turn == 0, "R8", "enable inside read turnaround", v_turn, 0);
    chk(v_gap == 0, "R9", "short strobe gap", v_gap, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_read();
    t_wait_states();
    t_timeout();
    t_back_to_back();
    t_monitors();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule